// File: doc/BRIEF.md
# Lane Start-Up and Polarity Monitor

This block sits on the receive side of a multi-lane serial link, after the symbol decoder. Every recovered-clock cycle it takes one decoded symbol per lane, with a shared valid strobe and per-lane code-violation, disparity and loss-of-signal flags. It looks for the training symbol on every lane and decides when the local end of the link is up. It also checks whether a lane arrives with its polarity swapped.

A build-time mode selects how a swapped lane is handled. In flag mode the swap is a fatal fault: it is latched and holds the link down until the master reset. In fix mode the block inverts that lane's symbols from then on and training continues. Faults are graded in three severities. Decoder flags are data-level and only counted. Loss of signal is link-level and drops the link. A polarity fault in flag mode is catastrophic. The link state and the link-level and catastrophic flags are passed into the system clock domain through two-stage synchronizers.

Top module: `lane_startup_mon`

## Requirements
- R1: In flag mode (CORRECT_POL=0), a lane whose valid symbol equals the bitwise complement of TRAIN_PAT on two consecutive valid cycles raises the catastrophic fault. The lane's symbols pass through uncorrected, and rx_lane_inv_o stays 0.
- R2: In fix mode (CORRECT_POL=1), the same two-symbol detection toggles that lane's bit in rx_lane_inv_o. From the next cycle on, the lane's symbols are XORed with all ones before any other use. The catastrophic fault never rises, and the link can still train up.
- R3: The catastrophic fault, once raised, stays set until rx_rst_n is asserted. While it is set, rx_link_up_o is 0.
- R4: Each valid cycle in which any lane has its code-violation or disparity flag set adds one to rx_err_cnt_o (which stops at all ones). Such a cycle breaks a training run, but it does not drop a link that is up.
- R5: A loss-of-signal flag on any lane takes rx_link_up_o low two cycles after the input, and raises the link-level fault flag.
- R6: From the training state, rx_link_up_o rises once UP_RUN (16) consecutive valid cycles have carried TRAIN_PAT, free of errors, on every lane. Any other valid cycle restarts the count, and cycles with rx_vld_i low neither add to it nor clear it. The output rises two cycles after the last training symbol is presented.
- R7: While up, RETRAIN_RUN (8) consecutive valid all-lane training cycles from the far end return the block to training (rx_link_up_o low). Fewer than eight, followed by a non-training symbol, leave it up.
- R8: sys_link_up_o, sys_link_err_o and sys_cat_err_o follow the recovered-domain link state, link-level flag and catastrophic flag through two system-clock flops. This gives two to three system cycles of delay on both rising and falling edges.
- R9: After reset, rx_link_up_o is 0, rx_err_cnt_o is 0, rx_lane_inv_o is 0, and all system-domain outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered clock |
| rx_rst_n | input | 1 | Master reset, synchronous active-low, recovered domain |
| rx_sym_i | input | LANES*SYM_W | Decoded symbols, lane 0 in the low bits |
| rx_vld_i | input | 1 | Symbols valid this cycle (all lanes) |
| rx_code_err_i | input | LANES | Per-lane invalid-code flag from the decoder |
| rx_disp_err_i | input | LANES | Per-lane running-disparity flag from the decoder |
| rx_los_i | input | LANES | Per-lane loss of signal |
| rx_sym_o | output | LANES*SYM_W | Polarity-corrected symbols, one cycle late |
| rx_lane_inv_o | output | LANES | Lanes currently being inverted |
| rx_link_up_o | output | 1 | Link up, recovered domain |
| rx_err_cnt_o | output | ERR_CNT_W | Data-level error cycles since reset |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| sys_link_up_o | output | 1 | Synchronized link up |
| sys_link_err_o | output | 1 | Synchronized link-level fault |
| sys_cat_err_o | output | 1 | Synchronized catastrophic fault |

## Verification
A wrong training-run count shows on rx_link_up_o in the cycle the link should have risen or fallen. That is two recovered cycles after the sixteenth, or eighth, training symbol, so an off-by-one shows as a one-cycle difference. A wrong inversion state shows at once on rx_sym_o in the next cycle, and in flag mode as a catastrophic flag that is missing or spurious. A loss of the fault latch shows as sys_cat_err_o falling with no reset. Errors in the synchronizer show as system outputs that arrive a cycle early or late against a two-flop model.

// File: rtl/lsm_pkg.sv
// Shared types for the lane start-up monitor.
// Assumes: all lanes share one valid strobe.
package lsm_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_TRAIN = 2'd1,
        ST_UP    = 2'd2
    } link_st_e;

    // Registered per-lane observations handed from a lane monitor to the link FSM.
    typedef struct packed {
        logic vld;    // symbol was valid
        logic train;  // corrected symbol is the training pattern, error-free
        logic derr;   // data-level error (code or disparity)
        logic los;    // loss of signal
        logic pol;    // polarity fault to escalate (flag mode only)
    } lane_stat_t;

endpackage

// File: rtl/lsm_lane_mon.sv
// Per-lane monitor. It corrects polarity when enabled, detects an inverted
// training pattern on two consecutive valid symbols, and registers the
// per-lane status flags. Assumes the decoder flags align with sym_i.
module lsm_lane_mon #(
    parameter int                 SYM_W       = 8,
    parameter logic [SYM_W-1:0]   TRAIN_PAT   = 8'hBC,
    parameter bit                 CORRECT_POL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SYM_W-1:0]     sym_i,
    input  logic                 vld_i,
    input  logic                 code_err_i,
    input  logic                 disp_err_i,
    input  logic                 los_i,
    output logic [SYM_W-1:0]     sym_o,
    output logic                 inv_o,
    output lsm_pkg::lane_stat_t  stat_o
);

    logic [SYM_W-1:0] cor_sym;
    logic             is_comp;
    logic             inv_det;
    logic             inv_q;
    logic             prev_comp_q;

    // Apply the current inversion and classify the symbol.
    always_comb begin
        cor_sym = sym_i ^ {SYM_W{inv_q}};
        is_comp = vld_i && (cor_sym == ~TRAIN_PAT);
        inv_det = is_comp && prev_comp_q;
    end

    // Track the complement history and the inversion state, and register outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q        <= 1'b0;
            prev_comp_q  <= 1'b0;
            sym_o        <= '0;
            stat_o       <= '0;
        end else begin
            if (vld_i) begin
                prev_comp_q <= is_comp;
            end
            if (CORRECT_POL && inv_det) begin
                inv_q <= ~inv_q;
            end
            sym_o        <= cor_sym;
            stat_o.vld   <= vld_i;
            stat_o.train <= vld_i && (cor_sym == TRAIN_PAT) && !code_err_i && !disp_err_i;
            stat_o.derr  <= vld_i && (code_err_i || disp_err_i);
            stat_o.los   <= los_i;
            stat_o.pol   <= inv_det && !CORRECT_POL;
        end
    end

    assign inv_o = inv_q;

endmodule

// File: rtl/lsm_link_fsm.sv
// Link start-up FSM (RESET, TRAIN, UP). It counts training runs, grades
// faults, latches the catastrophic fault and counts data errors.
// Assumes lane status arrives registered and aligned across lanes.
module lsm_link_fsm #(
    parameter int LANES       = 2,
    parameter int UP_RUN      = 16,
    parameter int RETRAIN_RUN = 8,
    parameter int ERR_CNT_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  lsm_pkg::lane_stat_t  stat_i [LANES],
    output logic                 link_up_o,
    output logic                 link_err_o,
    output logic                 cat_o,
    output logic [ERR_CNT_W-1:0] err_cnt_o
);

    localparam int RUN_MAX = (UP_RUN > RETRAIN_RUN) ? UP_RUN : RETRAIN_RUN;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam logic [RUN_W-1:0] UP_LAST = RUN_W'(UP_RUN - 1);
    localparam logic [RUN_W-1:0] RT_LAST = RUN_W'(RETRAIN_RUN - 1);

    lsm_pkg::link_st_e st_q;
    logic [RUN_W-1:0]  run_q;
    logic              all_vld, all_train, any_derr, any_los, any_pol;

    // Reduce the per-lane flags to link-wide conditions.
    always_comb begin
        all_vld   = 1'b1;
        all_train = 1'b1;
        any_derr  = 1'b0;
        any_los   = 1'b0;
        any_pol   = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            all_vld   = all_vld   & stat_i[l].vld;
            all_train = all_train & stat_i[l].train;
            any_derr  = any_derr  | stat_i[l].derr;
            any_los   = any_los   | stat_i[l].los;
            any_pol   = any_pol   | stat_i[l].pol;
        end
    end

    // Fault grading: link-level follows LOS, catastrophic is sticky, data errors are counted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_err_o <= 1'b0;
            cat_o      <= 1'b0;
            err_cnt_o  <= '0;
        end else begin
            link_err_o <= any_los;
            cat_o      <= cat_o | any_pol;
            if (any_derr && (err_cnt_o != '1)) begin
                err_cnt_o <= err_cnt_o + ERR_CNT_W'(1);
            end
        end
    end

    // State transitions and the training-run counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= lsm_pkg::ST_RESET;
            run_q <= '0;
        end else if (cat_o || any_pol) begin
            st_q  <= lsm_pkg::ST_RESET;
            run_q <= '0;
        end else begin
            unique case (st_q)
                lsm_pkg::ST_RESET: begin
                    st_q  <= lsm_pkg::ST_TRAIN;
                    run_q <= '0;
                end
                lsm_pkg::ST_TRAIN: begin
                    if (any_los) begin
                        run_q <= '0;
                    end else if (all_vld) begin
                        if (!all_train) begin
                            run_q <= '0;
                        end else if (run_q == UP_LAST) begin
                            st_q  <= lsm_pkg::ST_UP;
                            run_q <= '0;
                        end else begin
                            run_q <= run_q + RUN_W'(1);
                        end
                    end
                end
                lsm_pkg::ST_UP: begin
                    if (any_los) begin
                        st_q  <= lsm_pkg::ST_TRAIN;
                        run_q <= '0;
                    end else if (all_vld) begin
                        if (!all_train) begin
                            run_q <= '0;
                        end else if (run_q == RT_LAST) begin
                            st_q  <= lsm_pkg::ST_TRAIN;
                            run_q <= '0;
                        end else begin
                            run_q <= run_q + RUN_W'(1);
                        end
                    end
                end
                default: begin
                    st_q  <= lsm_pkg::ST_RESET;
                    run_q <= '0;
                end
            endcase
        end
    end

    assign link_up_o = (st_q == lsm_pkg::ST_UP);

endmodule

// File: rtl/lsm_sync.sv
// Two-flop synchronizer bank into the destination clock domain.
// Assumes every input bit is a registered level in the source domain.
module lsm_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;

    // Two capture stages, both cleared by the destination reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end

endmodule

// File: rtl/lane_startup_mon.sv
// Top of the lane start-up and polarity monitor. It holds one monitor per
// lane, the link FSM, and the synchronizer into the system domain.
// Assumes rx_rst_n and sys_rst_n are each synchronous to their own clock.
module lane_startup_mon #(
    parameter int               LANES       = 2,
    parameter int               SYM_W       = 8,
    parameter logic [SYM_W-1:0] TRAIN_PAT   = 8'hBC,
    parameter bit               CORRECT_POL = 1'b1,
    parameter int               UP_RUN      = 16,
    parameter int               RETRAIN_RUN = 8,
    parameter int               ERR_CNT_W   = 8
) (
    input  logic                   rx_clk,
    input  logic                   rx_rst_n,
    input  logic [LANES*SYM_W-1:0] rx_sym_i,
    input  logic                   rx_vld_i,
    input  logic [LANES-1:0]       rx_code_err_i,
    input  logic [LANES-1:0]       rx_disp_err_i,
    input  logic [LANES-1:0]       rx_los_i,
    output logic [LANES*SYM_W-1:0] rx_sym_o,
    output logic [LANES-1:0]       rx_lane_inv_o,
    output logic                   rx_link_up_o,
    output logic [ERR_CNT_W-1:0]   rx_err_cnt_o,
    input  logic                   sys_clk,
    input  logic                   sys_rst_n,
    output logic                   sys_link_up_o,
    output logic                   sys_link_err_o,
    output logic                   sys_cat_err_o
);

    localparam int SYNC_W = 3;

    lsm_pkg::lane_stat_t lane_stat [LANES];
    logic                rx_link_err;
    logic                rx_cat;
    logic [SYNC_W-1:0]   sync_q;

    // One monitor per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lsm_lane_mon #(
            .SYM_W       (SYM_W),
            .TRAIN_PAT   (TRAIN_PAT),
            .CORRECT_POL (CORRECT_POL)
        ) u_mon (
            .clk        (rx_clk),
            .rst_n      (rx_rst_n),
            .sym_i      (rx_sym_i[g*SYM_W +: SYM_W]),
            .vld_i      (rx_vld_i),
            .code_err_i (rx_code_err_i[g]),
            .disp_err_i (rx_disp_err_i[g]),
            .los_i      (rx_los_i[g]),
            .sym_o      (rx_sym_o[g*SYM_W +: SYM_W]),
            .inv_o      (rx_lane_inv_o[g]),
            .stat_o     (lane_stat[g])
        );
    end

    lsm_link_fsm #(
        .LANES       (LANES),
        .UP_RUN      (UP_RUN),
        .RETRAIN_RUN (RETRAIN_RUN),
        .ERR_CNT_W   (ERR_CNT_W)
    ) u_fsm (
        .clk        (rx_clk),
        .rst_n      (rx_rst_n),
        .stat_i     (lane_stat),
        .link_up_o  (rx_link_up_o),
        .link_err_o (rx_link_err),
        .cat_o      (rx_cat),
        .err_cnt_o  (rx_err_cnt_o)
    );

    lsm_sync #(.W(SYNC_W)) u_sync (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d_i   ({rx_cat, rx_link_err, rx_link_up_o}),
        .q_o   (sync_q)
    );

    assign sys_link_up_o  = sync_q[0];
    assign sys_link_err_o = sync_q[1];
    assign sys_cat_err_o  = sync_q[2];

endmodule

// File: rtl/lane_startup_mon_chk.sv
// Property checker for lane_startup_mon, attached by bind.
module lane_startup_mon_chk #(
    parameter int LANES       = 2,
    parameter int ERR_CNT_W   = 8,
    parameter bit CORRECT_POL = 1'b1
) (
    input logic                 rx_clk,
    input logic                 rx_rst_n,
    input logic [LANES-1:0]     rx_los_i,
    input logic [LANES-1:0]     rx_lane_inv_o,
    input logic                 rx_link_up_o,
    input logic [ERR_CNT_W-1:0] rx_err_cnt_o,
    input logic                 cat
);

    // R3: the catastrophic flag never clears without reset.
    p_cat_sticky_r3: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        cat |=> cat);

    // R3: no link while the catastrophic flag is set.
    p_cat_blocks_up_r3: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        cat |-> !rx_link_up_o);

    // R5: loss of signal forces the link down two cycles later.
    p_los_drops_link_r5: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        (|rx_los_i) |=> ##1 !rx_link_up_o);

    // R4: the data error count never goes backwards.
    p_err_cnt_monotonic_r4: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        1'b1 |=> (rx_err_cnt_o >= $past(rx_err_cnt_o)));

    if (CORRECT_POL) begin : g_fix
        // R2: a change of inversion never comes with escalation.
        p_fix_no_cat_r2: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
            !$stable(rx_lane_inv_o) |-> !cat);
    end else begin : g_flag
        // R1: flag mode never inverts a lane.
        p_flag_no_invert_r1: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
            rx_lane_inv_o == '0);
    end

endmodule

bind lane_startup_mon lane_startup_mon_chk #(
    .LANES       (LANES),
    .ERR_CNT_W   (ERR_CNT_W),
    .CORRECT_POL (CORRECT_POL)
) u_chk (
    .rx_clk        (rx_clk),
    .rx_rst_n      (rx_rst_n),
    .rx_los_i      (rx_los_i),
    .rx_lane_inv_o (rx_lane_inv_o),
    .rx_link_up_o  (rx_link_up_o),
    .rx_err_cnt_o  (rx_err_cnt_o),
    .cat           (rx_cat)
);

// File: tb/lane_startup_mon_bench.sv
// Bench: two instances (fix mode and flag mode) fed the same stimulus and
// compared on every clock against a behavioural reference model.
module lane_startup_mon_bench;

    localparam int RX_PERIOD  = 8;
    localparam int SYS_PERIOD = 10;
    localparam int LANES = 2;
    localparam int SW    = 8;
    localparam logic [7:0] PAT  = 8'hBC;
    localparam logic [7:0] NPAT = ~PAT;

    logic rx_clk = 1'b0, sys_clk = 1'b0, rst_n = 1'b0;
    logic [LANES*SW-1:0] sym = '0;
    logic vld = 1'b0;
    logic [LANES-1:0] ce = '0, de = '0, los = '0;

    logic [LANES*SW-1:0] so [2];
    logic [LANES-1:0]    inv [2];
    logic                up [2], sup [2], serr [2], scat [2];
    logic [7:0]          cnt [2];

    always #(RX_PERIOD/2) rx_clk = ~rx_clk;
    always #(SYS_PERIOD/2) sys_clk = ~sys_clk;

    lane_startup_mon #(.CORRECT_POL(1'b1)) u_lane_startup_mon (
        .rx_clk(rx_clk), .rx_rst_n(rst_n), .rx_sym_i(sym), .rx_vld_i(vld),
        .rx_code_err_i(ce), .rx_disp_err_i(de), .rx_los_i(los),
        .rx_sym_o(so[0]), .rx_lane_inv_o(inv[0]), .rx_link_up_o(up[0]), .rx_err_cnt_o(cnt[0]),
        .sys_clk(sys_clk), .sys_rst_n(rst_n),
        .sys_link_up_o(sup[0]), .sys_link_err_o(serr[0]), .sys_cat_err_o(scat[0]));

    lane_startup_mon #(.CORRECT_POL(1'b0)) u_lane_startup_mon_det (
        .rx_clk(rx_clk), .rx_rst_n(rst_n), .rx_sym_i(sym), .rx_vld_i(vld),
        .rx_code_err_i(ce), .rx_disp_err_i(de), .rx_los_i(los),
        .rx_sym_o(so[1]), .rx_lane_inv_o(inv[1]), .rx_link_up_o(up[1]), .rx_err_cnt_o(cnt[1]),
        .sys_clk(sys_clk), .sys_rst_n(rst_n),
        .sys_link_up_o(sup[1]), .sys_link_err_o(serr[1]), .sys_cat_err_o(scat[1]));

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model (mode 0 = fix, 1 = flag) ----------------
    bit         m_inv [2][LANES], m_prev [2][LANES];
    bit         m_tr [2][LANES], m_de [2][LANES], m_ls [2][LANES], m_pl [2][LANES], m_vl [2];
    logic [7:0] m_sym [2][LANES];
    int         m_st [2], m_run [2], m_cnt [2];   // st: 0 reset, 1 train, 2 up
    bit         m_cat [2], m_lerr [2];
    bit         s1 [2][3], s2 [2][3];

    always @(posedge rx_clk) begin
        for (int m = 0; m < 2; m++) begin
            if (!rst_n) begin
                m_st[m] = 0; m_run[m] = 0; m_cnt[m] = 0; m_cat[m] = 0; m_lerr[m] = 0; m_vl[m] = 0;
                for (int l = 0; l < LANES; l++) begin
                    m_inv[m][l] = 0; m_prev[m][l] = 0; m_tr[m][l] = 0; m_de[m][l] = 0;
                    m_ls[m][l] = 0; m_pl[m][l] = 0; m_sym[m][l] = 8'h00;
                end
            end else begin
                bit at, ad, al, ap;
                logic [7:0] c;
                bit comp, det;
                at = m_vl[m]; ad = 0; al = 0; ap = 0;
                for (int l = 0; l < LANES; l++) begin
                    at = at && m_tr[m][l]; ad = ad || m_de[m][l];
                    al = al || m_ls[m][l]; ap = ap || m_pl[m][l];
                end
                m_lerr[m] = al;
                if (ad && m_cnt[m] < 255) m_cnt[m]++;
                if (m_cat[m] || ap) begin m_st[m] = 0; m_run[m] = 0; end
                else if (m_st[m] == 0) begin m_st[m] = 1; m_run[m] = 0; end
                else if (al) begin m_run[m] = 0; if (m_st[m] == 2) m_st[m] = 1; end
                else if (m_vl[m]) begin
                    if (!at) m_run[m] = 0;
                    else begin
                        m_run[m]++;
                        if (m_st[m] == 1 && m_run[m] == 16) begin m_st[m] = 2; m_run[m] = 0; end
                        else if (m_st[m] == 2 && m_run[m] == 8) begin m_st[m] = 1; m_run[m] = 0; end
                    end
                end
                m_cat[m] = m_cat[m] || ap;
                m_vl[m] = vld;
                for (int l = 0; l < LANES; l++) begin
                    c = sym[l*SW +: SW] ^ {SW{m_inv[m][l]}};
                    comp = vld && (c == NPAT);
                    det = comp && m_prev[m][l];
                    if (vld) m_prev[m][l] = comp;
                    m_sym[m][l] = c;
                    m_tr[m][l] = vld && c == PAT && !ce[l] && !de[l];
                    m_de[m][l] = vld && (ce[l] || de[l]);
                    m_ls[m][l] = los[l];
                    m_pl[m][l] = det && (m == 1);
                    if (det && m == 0) m_inv[m][l] = !m_inv[m][l];
                end
            end
        end
    end

    always @(posedge sys_clk) begin
        for (int m = 0; m < 2; m++) begin
            if (!rst_n) begin
                for (int k = 0; k < 3; k++) begin s1[m][k] = 0; s2[m][k] = 0; end
            end else begin
                for (int k = 0; k < 3; k++) s2[m][k] = s1[m][k];
                s1[m][0] = (m_st[m] == 2); s1[m][1] = m_lerr[m]; s1[m][2] = m_cat[m];
            end
        end
    end

    // Per-cycle comparison, away from the active edges.
    always @(negedge rx_clk) begin
        for (int m = 0; m < 2; m++) begin
            chk("R6", "rx_link_up", up[m], m_st[m] == 2);
            chk("R4", "rx_err_cnt", cnt[m], m_cnt[m]);
            for (int l = 0; l < LANES; l++) begin
                chk("R2", "lane_inv", inv[m][l], m_inv[m][l]);
                chk("R1", "rx_sym", so[m][l*SW +: SW], m_sym[m][l]);
            end
        end
    end

    always @(negedge sys_clk) begin
        for (int m = 0; m < 2; m++) begin
            chk("R8", "sys_link_up", sup[m], s2[m][0]);
            chk("R5", "sys_link_err", serr[m], s2[m][1]);
            chk("R3", "sys_cat_err", scat[m], s2[m][2]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input logic [7:0] a, input logic [7:0] b, input bit v = 1'b1,
                       input logic [1:0] c = 2'b00, input logic [1:0] d = 2'b00,
                       input logic [1:0] s = 2'b00);
        @(negedge rx_clk);
        sym = {b, a}; vld = v; ce = c; de = d; los = s;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(sym[7:0], sym[15:8], 1'b0);
    endtask

    task automatic trains(input int n, input logic [7:0] b = PAT);
        for (int i = 0; i < n; i++) put(PAT, b);
    endtask

    task automatic do_reset;
        @(negedge rx_clk); rst_n = 1'b0; vld = 1'b0; ce = '0; de = '0; los = '0; sym = '0;
        repeat (4) @(negedge rx_clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge rx_clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        idle(2);
        // R9: reset state
        chk("R9", "link_up after reset", up[0], 0);
        chk("R9", "err_cnt after reset", cnt[0], 0);
        chk("R9", "lane_inv after reset", inv[0], 0);
        chk("R9", "sys_link_up after reset", sup[0], 0);

        // R6: 15 trains then data does not bring the link up
        trains(15); put(8'h11, 8'h22); idle(2);
        chk("R6", "up after 15 trains", up[0], 0);
        // R6: 16 consecutive trains, with a gap of invalid cycles that does not break the run
        trains(10); idle(3); trains(6); idle(2);
        chk("R6", "up after 16 trains", up[0], 1);
        idle(3);
        chk("R8", "sys_link_up follows", sup[0], 1);

        // R4: data errors counted, link stays up
        put(8'h11, 8'h22, 1'b1, 2'b01, 2'b00);
        put(8'h33, 8'h44, 1'b1, 2'b00, 2'b10);
        put(8'h55, 8'h66, 1'b1, 2'b11, 2'b11);
        idle(2);
        chk("R4", "error count", cnt[0], 3);
        chk("R4", "still up after data errors", up[0], 1);

        // R7: 7 trains then data keeps link; 8 trains drops it
        trains(7); put(8'h12, 8'h34); idle(2);
        chk("R7", "up after 7 trains", up[0], 1);
        trains(8); idle(2);
        chk("R7", "retrain after 8 trains", up[0], 0);

        // R5: loss of signal drops the link
        trains(16); idle(2);
        chk("R5", "up before los", up[0], 1);
        put(PAT, PAT, 1'b1, 2'b00, 2'b00, 2'b10); idle(2);
        chk("R5", "down after los", up[0], 0);

        // R1/R2: lane 1 arrives inverted
        do_reset();
        trains(2, NPAT);
        trains(16, NPAT);
        idle(2);
        chk("R2", "fix mode inv", inv[0], 2'b10);
        chk("R2", "fix mode corrected sym", so[0][15:8], PAT);
        chk("R2", "fix mode link up", up[0], 1);
        chk("R1", "flag mode no inv", inv[1], 0);
        chk("R1", "flag mode raw sym", so[1][15:8], NPAT);
        chk("R3", "flag mode link down", up[1], 0);
        idle(4);
        chk("R1", "flag mode sys cat", scat[1], 1);
        chk("R2", "fix mode sys cat", scat[0], 0);
        // R3: catastrophic stays through good training
        put(PAT, PAT); put(PAT, PAT);
        trains(16); idle(4);
        chk("R3", "cat holds", scat[1], 1);
        chk("R3", "still down", up[1], 0);

        // R3: reset clears it
        do_reset();
        trains(16); idle(4);
        chk("R3", "flag mode up after reset", up[1], 1);
        chk("R3", "cat cleared", scat[1], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule